// File: doc/BRIEF.md
# Register File with Constant Registers

This block is the architectural register store of a small 32-bit RISC core. It holds 32 words of 32 bits each. Two read ports serve the decode stage. Each read port takes a 5-bit index and returns that register's word in the same cycle. One write port serves the write-back stage. It takes an index, a data word and an enable, and it commits on the rising clock edge.

Two indices never hold a stored value. Index 30 always reads as zero and index 31 always reads as one. A write aimed at either of them is accepted and then thrown away. This lets software use them as ready-made constants.

When a write and a read target the same general register in the same cycle, the read returns the word being written. The pipeline therefore needs no separate forwarding path from write-back to decode. The general registers are not cleared by reset, so the array fits distributed or block RAM. While reset is asserted, the write port is held off so that a flushing pipeline cannot corrupt state.

Top module: `rfc_regfile`

## Requirements
- R1: The file has 32 entries of 32 bits, selected by 5-bit indices, and offers two read ports. The two read ports work independently of each other. Each port's data follows its index within the same cycle, with no clock edge in between.
- R2: Indices 0 to 29 are general registers. On a rising edge with `wr_en` = 1 and `rst` = 0, `wr_data` is stored at `wr_idx`. That register then reads back that value until it is next written.
- R3: Reading index 30 (5'b11110) always returns 32'h0000_0000, in every cycle, including during reset.
- R4: Reading index 31 (5'b11111) always returns 32'h0000_0001, in every cycle, including during reset.
- R5: A write to index 30 or 31 has no effect: later reads of those indices still return 0 and 1. A read of them in the same cycle as the write also returns the constant, not `wr_data`.
- R6: With `wr_en` = 0, nothing is written, whatever `wr_idx` and `wr_data` hold.
- R7: If `wr_en` = 1, `rst` = 0 and `wr_idx` names a general register equal to a read port's index, then that port returns `wr_data` in the same cycle.
- R8: While `rst` = 1, the write port is disabled. Reset does not clear the general registers: a value written before reset still reads back after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes while high |
| wr_en | input | 1 | Write enable from write-back |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | 32 | Word to be written |
| rd_idx_a | input | 5 | Index for read port A |
| rd_data_a | output | 32 | Word read on port A |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_b | output | 32 | Word read on port B |

## Verification
The bench builds the block with its default parameters. These are 32-bit words, 5-bit indices, constants at 30 and 31, and same-cycle write bypass enabled. With these values the whole index space is small enough to sweep: every register is written with a distinct pattern and read back on both ports in opposite orders. This brings into reach the top-edge corner where a constant index is also the write target and the bypass must stay silent. It also covers the bypass on the highest general index, 29, the write blocked during reset, and the suppressed write with enable low.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  // Default geometry of the register file
  localparam int unsigned RFC_DATA_W = 32;
  localparam int unsigned RFC_IDX_W  = 5;
  localparam int unsigned RFC_ZERO_IDX = 30;
  localparam int unsigned RFC_ONE_IDX  = 31;

  // True when an index names one of the two hardwired constants
  function automatic logic rfc_is_fixed(input int unsigned idx,
                                        input int unsigned zero_idx,
                                        input int unsigned one_idx);
    return (idx == zero_idx) || (idx == one_idx);
  endfunction

endpackage

// File: rtl/rfc_write_ctrl.sv
module rfc_write_ctrl
  import rfc_pkg::*;
#(
  parameter int unsigned IDX_W    = RFC_IDX_W,
  parameter int unsigned ZERO_IDX = RFC_ZERO_IDX,
  parameter int unsigned ONE_IDX  = RFC_ONE_IDX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             commit
);

  logic idx_fixed;

  // Constants are never stored; reset holds the port off.
  always_comb begin
    idx_fixed = rfc_is_fixed(32'(wr_idx), ZERO_IDX, ONE_IDX);
    commit    = wr_en && !rst && !idx_fixed;
  end

  // R6: no enable, no commit
  a_r6_no_enable_no_commit: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !commit);

endmodule

// File: rtl/rfc_storage.sv
module rfc_storage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned N_RD   = 2
) (
  input  logic                    clk,
  input  logic                    commit,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [N_RD*IDX_W-1:0]   rd_idx_flat,
  output logic [N_RD*DATA_W-1:0]  rd_raw_flat
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  // No reset on the array, so it maps onto RAM resources
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) mem[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_raw_flat[p*DATA_W +: DATA_W] = mem[rd_idx_flat[p*IDX_W +: IDX_W]];
  end

endmodule

// File: rtl/rfc_read_port.sv
module rfc_read_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned ZERO_IDX = 30,
  parameter int unsigned ONE_IDX  = 31,
  parameter bit          BYPASS   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_raw,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [IDX_W-1:0]  ZIDX = IDX_W'(ZERO_IDX);
  localparam logic [IDX_W-1:0]  OIDX = IDX_W'(ONE_IDX);
  localparam logic [DATA_W-1:0] VAL_ONE = DATA_W'(1);

  logic [DATA_W-1:0] stored;

  if (BYPASS) begin : g_bypass
    // commit already excludes constants, reset and disabled writes
    assign stored = (commit && (wr_idx == rd_idx)) ? wr_data : rd_raw;
  end else begin : g_plain
    logic unused_byp;
    assign unused_byp = commit ^ (^wr_idx) ^ (^wr_data);
    assign stored = rd_raw;
  end

  always_comb begin
    if (rd_idx == ZIDX)      rd_data = '0;
    else if (rd_idx == OIDX) rd_data = VAL_ONE;
    else                     rd_data = stored;
  end

  // R3: zero register
  a_r3_zero_reads_zero: assert property (@(posedge clk)
    (rd_idx == ZIDX) |-> (rd_data == '0));
  // R4: one register
  a_r4_one_reads_one: assert property (@(posedge clk)
    (rd_idx == OIDX) |-> (rd_data == VAL_ONE));

  if (BYPASS) begin : g_chk_byp
    // R7: same-cycle write is visible on the read port
    a_r7_bypass_visible: assert property (@(posedge clk) disable iff (rst)
      (commit && wr_idx == rd_idx) |-> (rd_data == wr_data));
  end

endmodule

// File: rtl/rfc_regfile.sv
module rfc_regfile
  import rfc_pkg::*;
#(
  parameter int unsigned DATA_W   = RFC_DATA_W,
  parameter int unsigned IDX_W    = RFC_IDX_W,
  parameter int unsigned ZERO_IDX = RFC_ZERO_IDX,
  parameter int unsigned ONE_IDX  = RFC_ONE_IDX,
  parameter bit          BYPASS   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b
);

  localparam int unsigned N_RD = 2;
  localparam logic [IDX_W-1:0] OIDX = IDX_W'(ONE_IDX);
  localparam logic [IDX_W-1:0] ZIDX = IDX_W'(ZERO_IDX);

  logic                   commit;
  logic [N_RD*IDX_W-1:0]  rd_idx_flat;
  logic [N_RD*DATA_W-1:0] rd_raw_flat;
  logic [N_RD*DATA_W-1:0] rd_out_flat;

  assign rd_idx_flat = {rd_idx_b, rd_idx_a};

  rfc_write_ctrl #(
    .IDX_W(IDX_W), .ZERO_IDX(ZERO_IDX), .ONE_IDX(ONE_IDX)
  ) u_wctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .commit(commit)
  );

  rfc_storage #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .N_RD(N_RD)
  ) u_mem (
    .clk(clk), .commit(commit), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_flat(rd_idx_flat), .rd_raw_flat(rd_raw_flat)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_port
    rfc_read_port #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .ZERO_IDX(ZERO_IDX),
      .ONE_IDX(ONE_IDX), .BYPASS(BYPASS)
    ) u_rp (
      .clk(clk), .rst(rst), .commit(commit), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx_flat[p*IDX_W +: IDX_W]),
      .rd_raw(rd_raw_flat[p*DATA_W +: DATA_W]),
      .rd_data(rd_out_flat[p*DATA_W +: DATA_W])
    );
  end

  assign rd_data_a = rd_out_flat[0 +: DATA_W];
  assign rd_data_b = rd_out_flat[DATA_W +: DATA_W];

  // R2: a general write is read back on the next cycle
  a_r2_write_persists: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != ZIDX && wr_idx != OIDX) |=>
      (rd_idx_a != $past(wr_idx) || (wr_en && wr_idx == rd_idx_a) ||
       rd_data_a == $past(wr_data)));
  // R5: a write to the one register leaves it reading one
  a_r5_fixed_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == OIDX) |=>
      (rd_idx_b != OIDX || rd_data_b == DATA_W'(1)));

endmodule

// File: tb/sim_rfc_regfile.sv
`timescale 1ns/1ps
module sim_rfc_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx_a = 5'd30;
  logic [4:0]  rd_idx_b = 5'd31;
  logic [31:0] rd_data_a, rd_data_b;

  always #2.5 clk = ~clk;

  rfc_regfile u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
  );

  typedef struct {
    string       req;
    bit          port_b;
    logic [31:0] exp;
  } item_t;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] model [32];
  bit          known [32];
  bit          done = 1'b0;

  function automatic logic [31:0] pat(input int i, input int k);
    return {8'(i), 8'(k), 8'(8'hC3 ^ 8'(i)), 8'(8'h5A + 8'(k))};
  endfunction

  function automatic bit expect_of(input logic [4:0] r, input bit rs, input bit w,
                                   input logic [4:0] wa, input logic [31:0] wd,
                                   output logic [31:0] e);
    if (r == 5'd30) begin e = 32'h0; return 1'b1; end
    if (r == 5'd31) begin e = 32'h1; return 1'b1; end
    if (w && !rs && wa == r) begin e = wd; return 1'b1; end
    e = model[r];
    return known[r];
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected reads
  task automatic drive(input bit rs, input bit w, input logic [4:0] wa,
                       input logic [31:0] wd, input logic [4:0] ra,
                       input logic [4:0] rb, input string req);
    logic [31:0] e;
    @(negedge clk);
    rst = rs; wr_en = w; wr_idx = wa; wr_data = wd;
    rd_idx_a = ra; rd_idx_b = rb;
    if (expect_of(ra, rs, w, wa, wd, e)) sb.push_back('{req, 1'b0, e});
    if (expect_of(rb, rs, w, wa, wd, e)) sb.push_back('{req, 1'b1, e});
    if (w && !rs && wa < 5'd30) begin model[wa] = wd; known[wa] = 1'b1; end
  endtask

  // Monitor: samples just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.port_b ? rd_data_b : rd_data_a;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s port %s actual %h expected %h", it.req,
                   it.port_b ? "B" : "A", act, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) known[i] = 1'b0;
    // Reset state: constants readable while reset is high (R3, R4)
    drive(1, 0, 5'd0, 32'h0, 5'd30, 5'd31, "R3/R4 reset");
    drive(1, 0, 5'd0, 32'h0, 5'd31, 5'd30, "R4 reset");
    // Fill every index; port A watches the write in the same cycle (R7, R5)
    drive(0, 0, 5'd0, 32'h0, 5'd30, 5'd31, "R3");
    for (int i = 0; i < 32; i++)
      drive(0, 1, 5'(i), pat(i, 1), 5'(i), 5'((i + 1) % 32), "R7 R5 fill");
    // Readback in opposite orders on the two ports (R1, R2)
    for (int i = 0; i < 32; i++)
      drive(0, 0, 5'd0, 32'h0, 5'(i), 5'(31 - i), "R1 R2 readback");
    // Enable low: junk on the write bus must not land (R6)
    drive(0, 0, 5'd4, 32'hDEAD_BEEF, 5'd4, 5'd4, "R6 same cycle");
    drive(0, 0, 5'd0, 32'h0, 5'd4, 5'd3, "R6 after");
    // Writes to the constant indices are dropped (R5)
    drive(0, 1, 5'd30, 32'hFFFF_FFFF, 5'd30, 5'd31, "R5 write zero");
    drive(0, 1, 5'd31, 32'hFFFF_FFFF, 5'd30, 5'd31, "R5 write one");
    drive(0, 0, 5'd0, 32'h0, 5'd31, 5'd30, "R5 after");
    // Highest general index bypass and back-to-back rewrite (R7, R2)
    drive(0, 1, 5'd29, 32'h1234_5678, 5'd29, 5'd29, "R7 top general");
    drive(0, 1, 5'd29, 32'h8765_4321, 5'd28, 5'd29, "R7 rewrite");
    drive(0, 0, 5'd0, 32'h0, 5'd29, 5'd0, "R2 rewrite kept");
    // Write during reset is blocked; contents survive reset (R8)
    drive(1, 1, 5'd9, 32'hBAD0_0BAD, 5'd9, 5'd31, "R8 during reset");
    drive(1, 0, 5'd0, 32'h0, 5'd9, 5'd10, "R8 in reset");
    drive(0, 0, 5'd0, 32'h0, 5'd9, 5'd10, "R8 after reset");
    drive(0, 0, 5'd0, 32'h0, 5'd0, 5'd30, "R8 untouched");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule